// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synchronous static memory with registered inputs and a registered output. It is built for a shared data bus that never idles. Address, control and per-lane write enables are sampled on one rising clock edge. Write data for an operation is taken from the data input two rising edges after its address. Read data appears on the output register after that same second edge. Because reads and writes sit at the same pipeline depth, they can alternate on every cycle without a turnaround gap.

A 2-bit burst counter can supply the two low address bits, so a run of four accesses needs only one address. The burst order is interleaved or linear, chosen by a static select input. The block also provides:
- a clock enable that freezes the whole block;
- three chip-select inputs, decoded on the clock edge;
- per-lane write masking;
- an output enable that only gates the output drive, without waiting for a clock;
- a sleep input that freezes the block and keeps the memory contents.

The bidirectional data bus is modelled as a data input, a data output and a drive-enable flag.

Top module: `zsram_top`

## Requirements
- R1: For a read sampled on edge E0, the word at its address is on `q_o` and `q_oe_o` is 1 after edge E2, the second enabled edge following E0. It stays there until the next enabled edge.
- R2: For a write sampled on edge E0, the word written is the value on `d_i` at edge E2.
- R3: Reads and writes may be issued on consecutive cycles in any mix with no idle cycle. A read issued right after a write to the same address returns the newly written value.
- R4: With `adv_i`=0, the full external address is loaded and the burst count resets to 0. With `adv_i`=1, the count increments and the low two address bits come from the burst logic.
- R5: With `burst_lin_i`=0, the low address bits in a burst are the start offset XOR the count, giving 2,3,0,1 for start 2.
- R6: With `burst_lin_i`=1, the low address bits are the start offset plus the count modulo 4, giving 1,2,3,0 for start 1.
- R7: Bit k of `bw_ni` is active low and guards lane k, which is bits [9k+8:9k] of the word. On a write, only enabled lanes change.
- R8: A load selects the device only when `ce_ni`=0, `ce2_i`=1 and `ce2_ni`=0. Any other load is a deselect, which writes nothing and gives `q_oe_o`=0 after its E2. `q_oe_o` is 0 after reset.
- R9: While `cke_ni`=1, clock edges are ignored. Pipeline, burst state, memory and outputs all hold, whatever the other inputs are.
- R10: `oe_ni`=1 forces `q_oe_o` to 0 at once, without a clock edge, and changes no state.
- R11: While `sleep_i`=1, operations are ignored, memory contents are kept and `q_oe_o` is 0. Normal operation resumes when `sleep_i` returns to 0.
- R12: A burst continue (`adv_i`=1) arriving when the last load was a deselect is itself a deselect, and the burst count does not move.
- R13: A burst continue repeats the read or write type of its load and ignores `we_ni`. The byte-lane enables are sampled on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| ce_ni | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| ce2_ni | input | 1 | Second chip select, active low |
| adv_i | input | 1 | 0 loads an address, 1 continues the burst |
| we_ni | input | 1 | Write select on a load, active low |
| bw_ni | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| burst_lin_i | input | 1 | Burst order: 0 interleaved, 1 linear |
| oe_ni | input | 1 | Output drive enable, active low, not clocked |
| sleep_i | input | 1 | Sleep: freeze and turn off the output drive |
| d_i | input | LANES*LANE_W | Write data bus |
| q_o | output | LANES*LANE_W | Read data bus |
| q_oe_o | output | 1 | Read data bus drive enable |

## Verification
On every cycle, the assertions check four things:
- a frozen edge leaves the output register and its drive flag unchanged;
- a read leaving the last stage always turns the drive on, and a write or deselect there turns it off;
- a continue after a deselected load never produces an operation;
- each accepted continue steps the burst count by exactly one.

Data correctness can only be shown by the bench's scenarios. These cover lane merging, same-address read-after-write, both burst orders, chip-select decode, and that writes issued during clock-disable or sleep leave the memory untouched. The bench checks each of these against its own reference memory, with expected values delayed by the pipeline depth.

// File: rtl/zsram_pkg.sv
package zsram_pkg;
  typedef enum logic {
    BURST_INTERLEAVE = 1'b0,
    BURST_LINEAR     = 1'b1
  } burst_order_e;

  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] cnt,
                                              input burst_order_e order);
    return (order == BURST_LINEAR) ? (start + cnt) : (start ^ cnt);
  endfunction
endpackage

// File: rtl/zsram_burst.sv
module zsram_burst
  import zsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              op_valid_o,
  output logic              op_we_o,
  output logic [ADDR_W-1:0] op_addr_o
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nxt;
  logic              active_q, we_q;
  burst_order_e      order;

  assign order   = burst_order_e'(lin_i);
  assign cnt_nxt = cnt_q + 2'd1;

  always_comb begin
    if (!adv_i) begin
      op_valid_o = sel_i;
      op_we_o    = we_i;
      op_addr_o  = addr_i;
    end else begin
      // continue: type inherited from load, chip selects not consulted
      op_valid_o = active_q;
      op_we_o    = we_q;
      op_addr_o  = {base_q[ADDR_W-1 -: HI_W], burst_offset(base_q[1:0], cnt_nxt, order)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      we_q     <= 1'b0;
    end else if (en_i) begin
      if (!adv_i) begin
        active_q <= sel_i;
        base_q   <= addr_i;
        we_q     <= we_i;
        cnt_q    <= '0;
      end else if (active_q) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  AST_DESEL_CONTINUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !active_q) |-> !op_valid_o); // R12

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && active_q) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R4
endmodule

// File: rtl/zsram_array.sv
module zsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/zsram_pipe.sv
module zsram_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    op_valid_i,
  input  logic                    op_we_i,
  input  logic [ADDR_W-1:0]       op_addr_i,
  input  logic [LANES-1:0]        op_be_i,
  input  logic [LANES*LANE_W-1:0] rdata_i,
  output logic                    mem_we_o,
  output logic [LANES-1:0]        mem_be_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    drive_o
);
  localparam int DW = LANES * LANE_W;

  logic              s1_valid, s1_we, s2_valid, s2_we;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [DW-1:0]     q_q;
  logic              drive_q;

  // second stage acts on the same edge for both reads and writes, so no bypass is needed
  assign mem_we_o   = en_i & s2_valid & s2_we;
  assign mem_be_o   = s2_be;
  assign mem_addr_o = s2_addr;
  assign q_o        = q_q;
  assign drive_o    = drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_we    <= 1'b0;
      s1_addr  <= '0;
      s1_be    <= '0;
      s2_valid <= 1'b0;
      s2_we    <= 1'b0;
      s2_addr  <= '0;
      s2_be    <= '0;
      q_q      <= '0;
      drive_q  <= 1'b0;
    end else if (en_i) begin
      s1_valid <= op_valid_i;
      s1_we    <= op_we_i;
      s1_addr  <= op_addr_i;
      s1_be    <= op_be_i;
      s2_valid <= s1_valid;
      s2_we    <= s1_we;
      s2_addr  <= s1_addr;
      s2_be    <= s1_be;
      if (s2_valid && !s2_we) begin
        q_q     <= rdata_i;
        drive_q <= 1'b1;
      end else begin
        drive_q <= 1'b0;
      end
    end
  end

  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(q_q) && $stable(drive_q))); // R9

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && s2_valid && !s2_we) |=> drive_q); // R1

  AST_IDLE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (!s2_valid || s2_we)) |=> !drive_q); // R8
endmodule

// File: rtl/zsram_top.sv
module zsram_top
  import zsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_ni,
  input  logic                    ce_ni,
  input  logic                    ce2_i,
  input  logic                    ce2_ni,
  input  logic                    adv_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    burst_lin_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] d_i,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    q_oe_o
);
  localparam int DW = LANES * LANE_W;

  logic              en, sel;
  logic              op_valid, op_we;
  logic [ADDR_W-1:0] op_addr, mem_addr;
  logic              mem_we, drive;
  logic [LANES-1:0]  mem_be;
  logic [DW-1:0]     rdata;

  assign en  = ~cke_ni & ~sleep_i;
  assign sel = ~ce_ni & ce2_i & ~ce2_ni;

  zsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .adv_i      (adv_i),
    .sel_i      (sel),
    .we_i       (~we_ni),
    .lin_i      (burst_lin_i),
    .addr_i     (addr_i),
    .op_valid_o (op_valid),
    .op_we_o    (op_we),
    .op_addr_o  (op_addr)
  );

  zsram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .op_valid_i (op_valid),
    .op_we_i    (op_we),
    .op_addr_i  (op_addr),
    .op_be_i    (~bw_ni),
    .rdata_i    (rdata),
    .mem_we_o   (mem_we),
    .mem_be_o   (mem_be),
    .mem_addr_o (mem_addr),
    .q_o        (q_o),
    .drive_o    (drive)
  );

  zsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .be_i    (mem_be),
    .addr_i  (mem_addr),
    .wdata_i (d_i),
    .rdata_o (rdata)
  );

  // output drive gating is combinational: no clock needed
  assign q_oe_o = drive & ~oe_ni & ~sleep_i;
endmodule

// File: tb/zsram_top_bench.sv
module zsram_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int LANES = 2;
  localparam int LW = 9;
  localparam int DW = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cke_ni = 1'b0, ce_ni = 1'b1, ce2_i = 1'b1, ce2_ni = 1'b0, adv_i = 1'b0, we_ni = 1'b1;
  logic [LANES-1:0] bw_ni = '1;
  logic [AW-1:0] addr_i = '0;
  logic burst_lin_i = 1'b0, oe_ni = 1'b0, sleep_i = 1'b0;
  logic [DW-1:0] d_i = '0;
  logic [DW-1:0] q_o;
  logic q_oe_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  zsram_top #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) u_zsram_top (
    .clk_i(clk), .rst_ni(rst_ni), .cke_ni(cke_ni), .ce_ni(ce_ni), .ce2_i(ce2_i),
    .ce2_ni(ce2_ni), .adv_i(adv_i), .we_ni(we_ni), .bw_ni(bw_ni), .addr_i(addr_i),
    .burst_lin_i(burst_lin_i), .oe_ni(oe_ni), .sleep_i(sleep_i), .d_i(d_i),
    .q_o(q_o), .q_oe_o(q_oe_o)
  );

  int checks = 0, errors = 0, op_seq = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic          h_valid [3];
  logic          h_we    [3];
  logic [AW-1:0] h_addr  [3];
  logic [DW-1:0] h_data  [3];
  logic [LANES-1:0] h_be [3];
  string         h_tag   [3];

  logic          bm_active = 1'b0, bm_we = 1'b0;
  logic [AW-1:0] bm_base = '0;
  logic [1:0]    bm_cnt = '0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_out();
    logic exp_oe;
    exp_oe = h_valid[2] && !h_we[2] && !oe_ni && !sleep_i;
    chk(q_oe_o === exp_oe, sleep_i ? "R11" : h_tag[2], DW'(q_oe_o), DW'(exp_oe));
    if (exp_oe) chk(q_o === ref_mem[h_addr[2]], h_tag[2], q_o, ref_mem[h_addr[2]]);
  endtask

  task automatic step(input logic cke_n, input logic slp, input logic ce_n, input logic ce2,
                      input logic ce2_n, input logic adv, input logic we_n,
                      input logic [LANES-1:0] bw_n, input logic [AW-1:0] a,
                      input string tag, input bit oe_probe);
    logic sel, nv, nwe;
    logic [AW-1:0] na;
    logic [1:0] c, off;
    @(negedge clk);
    check_out();
    if (oe_probe && h_valid[2] && !h_we[2]) begin
      oe_ni = 1'b1; #1;
      chk(q_oe_o === 1'b0, "R10", DW'(q_oe_o), '0);
      oe_ni = 1'b0; #1;
      chk(q_oe_o === 1'b1, "R10", DW'(q_oe_o), DW'(1));
      chk(q_o === ref_mem[h_addr[2]], "R10", q_o, ref_mem[h_addr[2]]);
    end
    if (!cke_n && !slp) begin
      if (h_valid[1] && h_we[1]) begin
        d_i = h_data[1];
        for (int l = 0; l < LANES; l++)
          if (h_be[1][l]) ref_mem[h_addr[1]][l*LW +: LW] = h_data[1][l*LW +: LW];
      end else begin
        d_i = ~d_i;
      end
      sel = !ce_n && ce2 && !ce2_n;
      if (!adv) begin
        nv = sel; nwe = !we_n; na = a;
        bm_active = sel; bm_base = a; bm_we = !we_n; bm_cnt = 2'd0;
      end else begin
        nv = bm_active; nwe = bm_we;
        c = bm_cnt + 2'd1;
        off = burst_lin_i ? (bm_base[1:0] + c) : (bm_base[1:0] ^ c);
        na = {bm_base[AW-1:2], off};
        if (bm_active) bm_cnt = c;
      end
      for (int i = 2; i > 0; i--) begin
        h_valid[i] = h_valid[i-1]; h_we[i] = h_we[i-1]; h_addr[i] = h_addr[i-1];
        h_data[i] = h_data[i-1]; h_be[i] = h_be[i-1]; h_tag[i] = h_tag[i-1];
      end
      h_valid[0] = nv; h_we[0] = nwe; h_addr[0] = na; h_be[0] = ~bw_n; h_tag[0] = tag;
      h_data[0] = DW'(op_seq * 32'h9E37 + 32'h1A5);
    end else begin
      d_i = ~d_i;
    end
    cke_ni = cke_n; sleep_i = slp; ce_ni = ce_n; ce2_i = ce2; ce2_ni = ce2_n;
    adv_i = adv; we_ni = we_n; bw_ni = bw_n; addr_i = a;
    op_seq++;
  endtask

  task automatic nop(input bit probe = 0);
    step(0, 0, 1, 1, 0, 0, 1, '1, '0, "R8", probe);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] bw, input string tag);
    step(0, 0, 0, 1, 0, 0, 0, bw, a, tag, 0);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(0, 0, 0, 1, 0, 0, 1, '1, a, tag, 0);
  endtask
  task automatic cont(input logic we_n, input string tag);
    step(0, 0, 0, 1, 0, 1, we_n, '0, '0, tag, 0);
  endtask
  task automatic flush();
    repeat (3) nop();
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), '0, "R2");
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R1");
    flush();
  endtask

  task automatic t_turnaround();
    wr(5, '0, "R3"); rd(5, "R3"); wr(9, '0, "R3"); rd(5, "R3"); rd(9, "R3");
    wr(9, '0, "R3"); wr(10, '0, "R3"); rd(9, "R3"); rd(10, "R3");
    flush();
  endtask

  task automatic t_lanes();
    wr(12, 2'b10, "R7"); wr(13, 2'b01, "R7"); wr(14, 2'b11, "R7");
    rd(12, "R7"); rd(13, "R7"); rd(14, "R7");
    flush();
  endtask

  task automatic t_burst_interleave();
    burst_lin_i = 1'b0;
    wr(22, '0, "R4"); repeat (3) cont(1'b0, "R5");
    rd(22, "R4"); repeat (3) cont(1'b1, "R5");
    rd(6, "R5"); repeat (4) cont(1'b1, "R5");
    flush();
  endtask

  task automatic t_burst_linear();
    burst_lin_i = 1'b1;
    wr(33, '0, "R6"); repeat (3) cont(1'b0, "R6");
    rd(33, "R6"); repeat (4) cont(1'b1, "R6");
    flush();
    burst_lin_i = 1'b0;
  endtask

  task automatic t_chipsel();
    step(0, 0, 1, 1, 0, 0, 0, '0, 40, "R8", 0);
    step(0, 0, 0, 0, 0, 0, 0, '0, 40, "R8", 0);
    step(0, 0, 0, 1, 1, 0, 0, '0, 40, "R8", 0);
    step(0, 0, 1, 0, 1, 0, 1, '1, 40, "R8", 0);
    rd(40, "R8");
    flush();
  endtask

  task automatic t_clock_enable();
    rd(3, "R9");
    step(1, 0, 0, 1, 0, 0, 0, '0, 3, "R9", 0);
    step(1, 0, 0, 1, 0, 1, 0, '0, 3, "R9", 0);
    rd(4, "R9");
    step(1, 0, 0, 1, 0, 0, 0, '0, 4, "R9", 0);
    wr(3, '0, "R9");
    step(1, 0, 0, 1, 0, 0, 1, '1, 4, "R9", 0);
    rd(3, "R9"); rd(4, "R9");
    flush();
  endtask

  task automatic t_output_enable();
    wr(50, '0, "R10"); rd(50, "R10");
    nop(); nop(1); nop(1);
  endtask

  task automatic t_sleep();
    rd(7, "R11"); nop(); nop();
    step(0, 1, 0, 1, 0, 0, 0, '0, 7, "R11", 0);
    step(0, 1, 0, 1, 0, 0, 0, '0, 8, "R11", 0);
    step(0, 1, 0, 1, 0, 1, 0, '0, 8, "R11", 0);
    rd(7, "R11"); rd(8, "R11");
    flush();
  endtask

  task automatic t_adv_after_deselect();
    step(0, 0, 1, 1, 0, 0, 0, '0, 16, "R12", 0);
    step(0, 0, 0, 1, 0, 1, 0, '0, 16, "R12", 0);
    step(0, 0, 0, 1, 0, 1, 0, '0, 16, "R12", 0);
    rd(17, "R12"); rd(18, "R12"); rd(16, "R12");
    flush();
  endtask

  task automatic t_burst_type();
    wr(44, '0, "R13"); cont(1'b1, "R13"); cont(1'b1, "R13"); cont(1'b0, "R13");
    rd(44, "R13"); cont(1'b0, "R13"); cont(1'b0, "R13"); cont(1'b1, "R13");
    flush();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      h_valid[i] = 1'b0; h_we[i] = 1'b0; h_addr[i] = '0; h_data[i] = '0; h_be[i] = '0; h_tag[i] = "R8";
    end
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(q_oe_o === 1'b0, "R8", DW'(q_oe_o), '0);
    t_fill();
    t_turnaround();
    t_lanes();
    t_burst_interleave();
    t_burst_linear();
    t_chipsel();
    t_clock_enable();
    t_output_enable();
    t_sleep();
    t_adv_after_deselect();
    t_burst_type();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule